// File: doc/BRIEF.md
# Eight-Bit ALU with Per-Flag Write Enables

This block is the combinational arithmetic and logic unit of a small accumulator processor. Each cycle it takes an operation code, two 8-bit operands, the incoming carry and the incoming half-carry. It returns an 8-bit result with a result write-enable, five condition flags and one write-enable for each flag. The surrounding datapath writes the result only when the result enable is high. It writes each flag only when that flag's enable is high, so flags that an operation does not touch keep their old values.

The unit covers addition and subtraction with and without carry, compare, negate, increment and decrement. It also covers the bitwise operations, bit test, test, clear and complement, shifts and rotates through carry, and decimal adjust after a BCD addition. Each operation has its own rule for the flags: some it computes, some it forces to a constant and some it leaves alone. Compare, bit test and test drive the flags but assert no result write.

The unit holds no state. Register files, operand fetch, instruction decode and 16-bit operations are outside this block.

Top module: `alu8_core`

## Requirements
- R1: Operation codes on op_i are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 and, 6 or, 7 exclusive-or, 8 bit test, 9 clear, 10 complement, 11 negate, 12 increment, 13 decrement, 14 test, 15 shift left, 16 arithmetic shift right, 17 logical shift right, 18 rotate left, 19 rotate right and 20 decimal adjust. Flag vectors are ordered bit4 H, bit3 N, bit2 Z, bit1 V, bit0 C. A flags_o bit whose enable is low reads 0. Unless a rule below forces it, N equals result bit 7, and Z is 1 exactly when the result is zero.
- R2: Add and add-with-carry produce a+b (plus c_i for code 1), write the result and enable all five flags. H is the carry out of bit 3, C the carry out of bit 7 and V the signed overflow.
- R3: Subtract, subtract-with-borrow (borrow-in c_i) and compare produce a-b-borrow and enable N, Z, V and C. C is 1 when b plus the borrow exceeds a as unsigned values, and V is the signed overflow. H is not enabled. Compare drives the difference on res_o but keeps res_we_o low.
- R4: Negate produces 0-a and enables N, Z, V and C. C is 1 for any nonzero a, and V is 1 only for a=0x80.
- R5: And, or and exclusive-or write the bitwise result, enable N, Z and V with V=0, and leave C and H disabled.
- R6: Bit test drives a&b and test drives a on res_o with res_we_o low. Both set the flags as in R5.
- R7: Clear writes 0 and enables N, Z, V and C with the values N=0, Z=1, V=0 and C=0.
- R8: Complement writes the ones' complement of a and enables N, Z, V and C with V=0 and C=1.
- R9: Increment and decrement write a+1 and a-1, enable N, Z and V, and leave C disabled. V is 1 for a=0x7F on increment and for a=0x80 on decrement.
- R10: Shift left shifts in 0 and rotate left shifts in c_i. Both enable N, Z, V and C, with C equal to the old bit 7 and V equal to old bit 7 xor old bit 6.
- R11: Arithmetic shift right keeps bit 7, enables N, Z and C with C equal to the old bit 0, and leaves V disabled.
- R12: Logical shift right shifts in 0 and rotate right shifts c_i into bit 7. Both enable N, Z and C, force N=0, set C to the old bit 0 and leave V disabled.
- R13: Decimal adjust adds 0x06 when h_i is 1 or the low digit exceeds 9. It adds 0x60 when c_i is 1, the high digit exceeds 9, or the high digit exceeds 8 while the low digit exceeds 9. It writes the sum and enables N, Z, V and C with V=0. C is c_i or-ed with the high correction.
- R14: Codes 21 to 31 drive res_o=0 and res_we_o=0, with all flag outputs and flag enables at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| a_i | input | DW | First operand, the only operand of unary operations |
| b_i | input | DW | Second operand |
| c_i | input | 1 | Incoming carry flag |
| h_i | input | 1 | Incoming half-carry flag, used by decimal adjust |
| res_o | output | DW | Operation result |
| res_we_o | output | 1 | Result write-enable |
| flags_o | output | 5 | Flag values {H,N,Z,V,C} |
| flags_we_o | output | 5 | Per-flag write-enables {H,N,Z,V,C} |

## Verification
The bench builds the unit with its default width of 8, which is the only width at which decimal adjust and the bit-3 half-carry take their full meaning. At that width it sweeps all 32 operation codes, every value of a_i, both values of the carry and the half-carry, and a set of second operands. That set includes every multiple of 0x11 and the sign and nibble boundary values. The sweep therefore reaches every overflow, borrow and decimal-correction boundary, and all of the unused codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_ADD = 5'd0,
        OP_ADC = 5'd1,
        OP_SUB = 5'd2,
        OP_SBC = 5'd3,
        OP_CMP = 5'd4,
        OP_AND = 5'd5,
        OP_OR  = 5'd6,
        OP_EOR = 5'd7,
        OP_BIT = 5'd8,
        OP_CLR = 5'd9,
        OP_COM = 5'd10,
        OP_NEG = 5'd11,
        OP_INC = 5'd12,
        OP_DEC = 5'd13,
        OP_TST = 5'd14,
        OP_ASL = 5'd15,
        OP_ASR = 5'd16,
        OP_LSR = 5'd17,
        OP_ROL = 5'd18,
        OP_ROR = 5'd19,
        OP_DAA = 5'd20
    } alu_op_e;

    localparam int NFLAG = 5;
    localparam int FH = 4;
    localparam int FN = 3;
    localparam int FZ = 2;
    localparam int FV = 1;
    localparam int FC = 0;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e           op_i,
    input  logic [DW-1:0]     a_i,
    input  logic [DW-1:0]     b_i,
    input  logic              c_i,
    output logic [DW-1:0]     res_o,
    output logic              wr_o,
    output logic [NFLAG-1:0]  flg_o,
    output logic [NFLAG-1:0]  en_o
);
    localparam int MSB = DW - 1;
    localparam int NIB = DW / 2;

    logic [DW-1:0] x_d, y_d;
    logic          ci_d, borrow_d;
    logic [DW:0]   full_d;
    logic [NIB:0]  half_d;

    always_comb begin
        x_d      = a_i;
        y_d      = b_i;
        ci_d     = 1'b0;
        borrow_d = 1'b0;
        wr_o     = 1'b1;
        en_o     = '0;
        unique case (op_i)
            OP_ADD: begin
                en_o = 5'b11111;
            end
            OP_ADC: begin
                ci_d = c_i;
                en_o = 5'b11111;
            end
            OP_SUB, OP_CMP: begin
                y_d      = ~b_i;
                ci_d     = 1'b1;
                borrow_d = 1'b1;
                en_o     = 5'b01111;
                wr_o     = (op_i != OP_CMP);
            end
            OP_SBC: begin
                y_d      = ~b_i;
                ci_d     = ~c_i;
                borrow_d = 1'b1;
                en_o     = 5'b01111;
            end
            OP_NEG: begin
                x_d      = '0;
                y_d      = ~a_i;
                ci_d     = 1'b1;
                borrow_d = 1'b1;
                en_o     = 5'b01111;
            end
            OP_INC: begin
                y_d  = '0;
                ci_d = 1'b1;
                en_o = 5'b01110;
            end
            OP_DEC: begin
                y_d  = '1;
                en_o = 5'b01110;
            end
            default: begin
                wr_o = 1'b0;
            end
        endcase

        full_d = {1'b0, x_d} + {1'b0, y_d} + {{DW{1'b0}}, ci_d};
        half_d = {1'b0, x_d[NIB-1:0]} + {1'b0, y_d[NIB-1:0]} + {{NIB{1'b0}}, ci_d};
        res_o  = full_d[DW-1:0];

        flg_o     = '0;
        flg_o[FH] = half_d[NIB];
        flg_o[FN] = res_o[MSB];
        flg_o[FZ] = (res_o == '0);
        flg_o[FV] = (x_d[MSB] == y_d[MSB]) && (res_o[MSB] != x_d[MSB]);
        flg_o[FC] = full_d[DW] ^ borrow_d;
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e           op_i,
    input  logic [DW-1:0]     a_i,
    input  logic [DW-1:0]     b_i,
    output logic [DW-1:0]     res_o,
    output logic              wr_o,
    output logic [NFLAG-1:0]  flg_o,
    output logic [NFLAG-1:0]  en_o
);
    localparam int MSB = DW - 1;

    logic carry_d;

    always_comb begin
        wr_o    = 1'b1;
        en_o    = 5'b01110;
        carry_d = 1'b0;
        unique case (op_i)
            OP_AND: res_o = a_i & b_i;
            OP_OR:  res_o = a_i | b_i;
            OP_EOR: res_o = a_i ^ b_i;
            OP_BIT: begin
                res_o = a_i & b_i;
                wr_o  = 1'b0;
            end
            OP_TST: begin
                res_o = a_i;
                wr_o  = 1'b0;
            end
            OP_CLR: begin
                res_o = '0;
                en_o  = 5'b01111;
            end
            OP_COM: begin
                res_o   = ~a_i;
                carry_d = 1'b1;
                en_o    = 5'b01111;
            end
            default: begin
                res_o = '0;
                wr_o  = 1'b0;
                en_o  = '0;
            end
        endcase

        flg_o     = '0;
        flg_o[FN] = res_o[MSB];
        flg_o[FZ] = (res_o == '0);
        flg_o[FC] = carry_d;
    end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e           op_i,
    input  logic [DW-1:0]     a_i,
    input  logic              c_i,
    output logic [DW-1:0]     res_o,
    output logic              wr_o,
    output logic [NFLAG-1:0]  flg_o,
    output logic [NFLAG-1:0]  en_o
);
    localparam int MSB = DW - 1;

    logic left_d;
    logic neg_zero_d;

    always_comb begin
        wr_o       = 1'b1;
        left_d     = 1'b0;
        neg_zero_d = 1'b0;
        en_o       = 5'b01101;
        unique case (op_i)
            OP_ASL: begin
                res_o  = {a_i[MSB-1:0], 1'b0};
                left_d = 1'b1;
                en_o   = 5'b01111;
            end
            OP_ROL: begin
                res_o  = {a_i[MSB-1:0], c_i};
                left_d = 1'b1;
                en_o   = 5'b01111;
            end
            OP_ASR: res_o = {a_i[MSB], a_i[MSB:1]};
            OP_LSR: begin
                res_o      = {1'b0, a_i[MSB:1]};
                neg_zero_d = 1'b1;
            end
            OP_ROR: begin
                res_o      = {c_i, a_i[MSB:1]};
                neg_zero_d = 1'b1;
            end
            default: begin
                res_o = '0;
                wr_o  = 1'b0;
                en_o  = '0;
            end
        endcase

        flg_o     = '0;
        flg_o[FN] = res_o[MSB] & ~neg_zero_d;
        flg_o[FZ] = (res_o == '0);
        flg_o[FV] = left_d & (a_i[MSB] ^ a_i[MSB-1]);
        flg_o[FC] = left_d ? a_i[MSB] : a_i[0];
    end

endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic          h_i,
    input  logic          c_i,
    output logic [DW-1:0] res_o,
    output logic          c_o
);
    localparam int NIB = DW / 2;
    localparam logic [NIB-1:0] NINE  = NIB'(9);
    localparam logic [NIB-1:0] EIGHT = NIB'(8);
    localparam logic [NIB-1:0] SIX   = NIB'(6);

    logic [NIB-1:0] lo_d, hi_d;
    logic           lo_fix_d, hi_fix_d;
    logic [DW-1:0]  adj_d;

    always_comb begin
        lo_d     = a_i[NIB-1:0];
        hi_d     = a_i[DW-1:NIB];
        lo_fix_d = h_i || (lo_d > NINE);
        hi_fix_d = c_i || (hi_d > NINE) || ((hi_d > EIGHT) && (lo_d > NINE));
        adj_d    = {(hi_fix_d ? SIX : '0), (lo_fix_d ? SIX : '0)};
        res_o    = a_i + adj_d;
        c_o      = c_i | hi_fix_d;
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [4:0]        op_i,
    input  logic [DW-1:0]     a_i,
    input  logic [DW-1:0]     b_i,
    input  logic              c_i,
    input  logic              h_i,
    output logic [DW-1:0]     res_o,
    output logic              res_we_o,
    output logic [NFLAG-1:0]  flags_o,
    output logic [NFLAG-1:0]  flags_we_o
);
    localparam int MSB = DW - 1;

    typedef struct packed {
        logic [DW-1:0]    res;
        logic             wr;
        logic [NFLAG-1:0] fv;
        logic [NFLAG-1:0] fe;
    } pick_t;

    alu_op_e op_d;
    assign op_d = alu_op_e'(op_i);

    logic [DW-1:0]    ar_res, lg_res, sh_res, da_res;
    logic             ar_wr, lg_wr, sh_wr, da_c;
    logic [NFLAG-1:0] ar_flg, lg_flg, sh_flg;
    logic [NFLAG-1:0] ar_en, lg_en, sh_en;

    alu8_arith #(.DW(DW)) u_arith (
        .op_i(op_d), .a_i(a_i), .b_i(b_i), .c_i(c_i),
        .res_o(ar_res), .wr_o(ar_wr), .flg_o(ar_flg), .en_o(ar_en)
    );

    alu8_logic #(.DW(DW)) u_logic (
        .op_i(op_d), .a_i(a_i), .b_i(b_i),
        .res_o(lg_res), .wr_o(lg_wr), .flg_o(lg_flg), .en_o(lg_en)
    );

    alu8_shift #(.DW(DW)) u_shift (
        .op_i(op_d), .a_i(a_i), .c_i(c_i),
        .res_o(sh_res), .wr_o(sh_wr), .flg_o(sh_flg), .en_o(sh_en)
    );

    generate
        if (DW == 8) begin : g_bcd
            alu8_decadj #(.DW(DW)) u_decadj (
                .a_i(a_i), .h_i(h_i), .c_i(c_i),
                .res_o(da_res), .c_o(da_c)
            );
        end else begin : g_nobcd
            assign da_res = a_i;
            assign da_c   = c_i | h_i;
        end
    endgenerate

    pick_t pick_d;

    always_comb begin
        pick_d = '0;
        unique case (op_d)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP,
            OP_NEG, OP_INC, OP_DEC: begin
                pick_d = '{res: ar_res, wr: ar_wr, fv: ar_flg, fe: ar_en};
            end
            OP_AND, OP_OR, OP_EOR, OP_BIT, OP_TST,
            OP_CLR, OP_COM: begin
                pick_d = '{res: lg_res, wr: lg_wr, fv: lg_flg, fe: lg_en};
            end
            OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR: begin
                pick_d = '{res: sh_res, wr: sh_wr, fv: sh_flg, fe: sh_en};
            end
            OP_DAA: begin
                pick_d.res    = da_res;
                pick_d.wr     = 1'b1;
                pick_d.fv[FN] = da_res[MSB];
                pick_d.fv[FZ] = (da_res == '0);
                pick_d.fv[FC] = da_c;
                pick_d.fe     = 5'b01111;
            end
            default: pick_d = '0;
        endcase
    end

    assign res_o      = pick_d.res;
    assign res_we_o   = pick_d.wr;
    assign flags_o    = pick_d.fv & pick_d.fe;
    assign flags_we_o = pick_d.fe;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input logic [4:0]       op_i,
    input logic [DW-1:0]    a_i,
    input logic [DW-1:0]    b_i,
    input logic             c_i,
    input logic             h_i,
    input logic [DW-1:0]    res_o,
    input logic             res_we_o,
    input logic [NFLAG-1:0] flags_o,
    input logic [NFLAG-1:0] flags_we_o
);
    logic [DW:0] sum_ref;
    logic        keeps_c;

    always_comb begin
        sum_ref = {1'b0, a_i} + {1'b0, b_i};
        keeps_c = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_EOR) ||
                  (op_i == OP_BIT) || (op_i == OP_TST) || (op_i == OP_INC) ||
                  (op_i == OP_DEC);

        assert_masked_flags_R1: assert ((flags_o & ~flags_we_o) == '0)
            else $error("flag value set without enable");

        if (flags_we_o[FZ]) begin
            assert_zero_tracks_R1: assert (flags_o[FZ] == (res_o == '0))
                else $error("Z disagrees with result");
        end

        if (op_i == OP_ADD) begin
            assert_add_sum_R2: assert ({flags_o[FC], res_o} == sum_ref)
                else $error("add carry/result mismatch");
        end

        if (op_i == OP_CMP) begin
            assert_cmp_nowrite_R3: assert (!res_we_o && flags_we_o == 5'b01111)
                else $error("compare writes result or wrong enables");
        end

        if (keeps_c) begin
            assert_carry_kept_R5: assert (!flags_we_o[FC])
                else $error("carry enabled on carry-preserving op");
        end

        if (op_i == OP_CLR) begin
            assert_clear_consts_R7: assert (res_o == '0 && flags_we_o[3:0] == 4'hF &&
                                            flags_o[3:0] == 4'b0100)
                else $error("clear constants wrong");
        end

        if (op_i > 5'd20) begin
            assert_unused_idle_R14: assert (!res_we_o && flags_we_o == '0)
                else $error("unused code writes");
        end
    end

endmodule

bind alu8_core alu8_core_chk #(.DW(DW)) u_chk (.*);

// File: tb/alu8_core_test.sv
module alu8_core_test;

    logic       clk = 1'b0;
    logic [4:0] op;
    logic [7:0] a, b;
    logic       c, h;
    logic [7:0] res;
    logic       res_we;
    logic [4:0] flg, flg_we;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    alu8_core #(.DW(8)) uut (
        .op_i(op), .a_i(a), .b_i(b), .c_i(c), .h_i(h),
        .res_o(res), .res_we_o(res_we), .flags_o(flg), .flags_we_o(flg_we)
    );

    function automatic string req_of(int o);
        case (o)
            0, 1:        return "R2";
            2, 3, 4:     return "R3";
            11:          return "R4";
            5, 6, 7:     return "R5";
            8, 14:       return "R6";
            9:           return "R7";
            10:          return "R8";
            12, 13:      return "R9";
            15, 18:      return "R10";
            16:          return "R11";
            17, 19:      return "R12";
            20:          return "R13";
            default:     return "R14";
        endcase
    endfunction

    function automatic int sgn(int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    function automatic bit ovf(int v);
        return (v > 127) || (v < -128);
    endfunction

    // Expected {res[7:0], res_we, flags[4:0], flags_we[4:0]} from R1..R14
    function automatic logic [18:0] model(int o, int av, int bv, int cv, int hv);
        int r = 0, wr = 1, fe = 0, d, lo, hi, adj;
        bit fh = 0, fn, fz, fv = 0, fc = 0, nforce0 = 0;
        logic [4:0] f;
        case (o)
            0, 1: begin
                d  = av + bv + ((o == 1) ? cv : 0);
                r  = d & 255;
                fc = d > 255;
                fh = ((av & 15) + (bv & 15) + ((o == 1) ? cv : 0)) > 15;
                fv = ovf(sgn(av) + sgn(bv) + ((o == 1) ? cv : 0));
                fe = 5'b11111;
            end
            2, 3, 4: begin
                d  = av - bv - ((o == 3) ? cv : 0);
                r  = d & 255;
                fc = d < 0;
                fv = ovf(sgn(av) - sgn(bv) - ((o == 3) ? cv : 0));
                fe = 5'b01111;
                wr = (o != 4);
            end
            11: begin
                r  = (256 - av) & 255;
                fc = av != 0;
                fv = av == 128;
                fe = 5'b01111;
            end
            5:  begin r = av & bv; fe = 5'b01110; end
            6:  begin r = av | bv; fe = 5'b01110; end
            7:  begin r = av ^ bv; fe = 5'b01110; end
            8:  begin r = av & bv; fe = 5'b01110; wr = 0; end
            14: begin r = av;      fe = 5'b01110; wr = 0; end
            9:  begin r = 0;       fe = 5'b01111; end
            10: begin r = 255 - av; fc = 1; fe = 5'b01111; end
            12: begin r = (av + 1) & 255;   fv = av == 127; fe = 5'b01110; end
            13: begin r = (av + 255) & 255; fv = av == 128; fe = 5'b01110; end
            15, 18: begin
                r  = ((av * 2) + ((o == 18) ? cv : 0)) & 255;
                fc = av >= 128;
                fv = ((av >> 7) ^ (av >> 6)) & 1;
                fe = 5'b01111;
            end
            16: begin r = (av / 2) | (av & 128); fc = av & 1; fe = 5'b01101; end
            17, 19: begin
                r  = (av / 2) + ((o == 19) ? cv * 128 : 0);
                fc = av & 1;
                nforce0 = 1;
                fe = 5'b01101;
            end
            20: begin
                lo = av & 15; hi = av >> 4; adj = 0; fc = cv;
                if (hv == 1 || lo > 9) adj += 6;
                if (cv == 1 || hi > 9 || (hi > 8 && lo > 9)) begin adj += 96; fc = 1; end
                r  = (av + adj) & 255;
                fe = 5'b01111;
            end
            default: begin r = 0; wr = 0; fe = 0; end
        endcase
        fn = (r >= 128) && !nforce0;
        fz = (r == 0);
        f  = {fh, fn, fz, fv, fc};
        f  = f & 5'(fe);
        return {8'(r), 1'(wr), f, 5'(fe)};
    endfunction

    task automatic check(string tag);
        logic [18:0] exp, got;
        exp = model(int'(op), int'(a), int'(b), int'(c), int'(h));
        got = {res, res_we, flg, flg_we};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s op=%0d a=%02h b=%02h c=%0b h=%0b actual=%05h expected=%05h",
                     tag, op, a, b, c, h, got, exp);
        end
    endtask

    function automatic logic [7:0] b_pick(int i);
        case (i)
            16: return 8'h01;
            17: return 8'h0F;
            18: return 8'h7F;
            19: return 8'h80;
            20: return 8'hFE;
            21: return 8'h10;
            default: return 8'(i * 17);
        endcase
    endfunction

    initial begin
        op = 5'd0; a = 8'h00; b = 8'h00; c = 1'b0; h = 1'b0;
        #1;
        // Idle state with zero inputs: add of zeros yields Z only (R1, R2)
        check("R1");
        for (int o = 0; o < 32; o++) begin
            for (int av = 0; av < 256; av++) begin
                for (int bi = 0; bi < 22; bi++) begin
                    for (int cv = 0; cv < 2; cv++) begin
                        for (int hv = 0; hv < 2; hv++) begin
                            op = 5'(o); a = 8'(av); b = b_pick(bi);
                            c = 1'(cv); h = 1'(hv);
                            #1;
                            check(req_of(o));
                        end
                    end
                end
            end
        end
        // Directed corners
        op = 5'd11; a = 8'h80; b = 8'h00; c = 0; h = 0; #1; check("R4");
        op = 5'd12; a = 8'h7F; #1; check("R9");
        op = 5'd13; a = 8'h80; #1; check("R9");
        op = 5'd20; a = 8'h9A; c = 0; h = 0; #1; check("R13");
        op = 5'd19; a = 8'h01; c = 1; #1; check("R12");
        op = 5'd3;  a = 8'h00; b = 8'hFF; c = 1; #1; check("R3");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule